// File: doc/BRIEF.md
# IO MMU control and fault interrupt register block

This block is the software-visible control face of an IO address translation unit. Software reaches it over a simple single-cycle 32-bit register bus. Through it, software sets the operating mode: off, translating, or held. It also holds the configuration word and the page table root address, issues TLB invalidations, and services faults. The translation datapath lives elsewhere. That datapath reports faults through a fault strobe carrying a 3-bit fault kind and an address. It also reports through an idle input that rises once in-flight traffic has drained.

A block request moves the unit into a draining state. It reaches the held state only when the datapath reports idle. A fault is different: it forces the held state at once. The fault sets its own interrupt status bit and stores the faulting address in a register chosen by the channel the fault belongs to. The unit stays held until software writes the enable code again. The interrupt output is a level signal. It stays high while any status bit is set, and software clears the bits by writing ones.

Top module: `iommu_ctl_regs`

## Requirements
- R1: After reset, `xlate_en`, `halted` and `irq` are 0. The control (0x000), status (0x008), interrupt status (0x018), configuration (0x004) and page table base (0x014) registers read 0.
- R2: A control write of exactly 0x5 enables translation (`xlate_en`=1, control reads 0x5). A write of 0x0 turns the unit off (control reads 0x0). A write of any other value except 0x7 leaves the mode unchanged.
- R3: A control write of 0x7 drops `xlate_en` and makes control read 0x7. Status bit 0 and `halted` stay 0 while `path_idle` is low. They become 1 on the first clock edge after the write at which `path_idle` is sampled high.
- R4: A fault strobe accepted while the unit is not off sets the interrupt status bit at position `flt_kind` and forces the held state (`halted`=1, status bit 0 =1) at the same clock edge. The fault takes priority over a control write in the same cycle. A fault strobe while the unit is off changes nothing.
- R5: The fault address is stored by kind. Kind 0 (page fault) goes to 0x024. Kinds 2, 6 and 7 (write multi-hit, write security, write access) go to 0x028. Kinds 1, 4 and 5 (read multi-hit, read security, read access) go to 0x02C. Kind 3 (bus error) goes to 0x030.
- R6: Writing to interrupt clear (0x01C) clears every status bit written as 1 and leaves the others. A fault that sets a bit in the same cycle as a clear of that bit wins.
- R7: `irq` is high exactly while any interrupt status bit is set.
- R8: A control write of 0x5 leaves the held state, whether the unit was held by a block request or by a fault, even with status bits still set.
- R9: The configuration register keeps only bits 0-15, 20, 22 and 24 of a write (mask 0x0150FFFF); all other bits read 0. `cfg_q` shows the stored value.
- R10: Register 0x034 reads the 11-bit version parameter in bits [31:21] (major in [31:28], minor in [27:21]); the default reads 0x30600000.
- R11: A write to 0x00C pulses `inv_all` for exactly one cycle after the write edge. A write to 0x010 with bit 0 set pulses `inv_one` for one cycle with `inv_vpn` = write data [31:12]. With bit 0 clear, that write gives no pulse.
- R12: The page table base register at 0x014 stores and reads back all 32 bits and drives `ptbase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| flt_valid | input | 1 | Fault strobe from the datapath |
| flt_kind | input | 3 | Fault kind, also its interrupt bit position |
| flt_addr | input | 32 | Faulting address |
| path_idle | input | 1 | In-flight traffic has drained |
| xlate_en | output | 1 | Translation running |
| halted | output | 1 | Unit is in the held state |
| irq | output | 1 | Level interrupt |
| inv_all | output | 1 | One-cycle invalidate-all pulse |
| inv_one | output | 1 | One-cycle single-entry invalidate pulse |
| inv_vpn | output | 20 | Page number for `inv_one` |
| cfg_q | output | 32 | Stored configuration word |
| ptbase | output | 32 | Page table base |

## Verification
A wrong mode state shows on `xlate_en`, on `halted` and in the control readback one cycle after the write or fault that set it. A held unit that never releases on the enable code is therefore caught at the next check. A lost or misrouted fault shows as a wrong interrupt status bit, a stuck or silent `irq`, or an address landing in the wrong capture register; each appears at the cycle after the strobe. The same-cycle collisions are driven on purpose, because a wrong priority there changes only one bit for one cycle. The collisions are fault against clear, and fault against the enable write.

// File: rtl/iommu_ctl_regs.sv
module iommu_ctl_regs #(
  parameter int          AW         = 8,
  parameter logic [10:0] HW_VERSION = 11'h183,
  parameter logic [31:0] CFG_WMASK  = 32'h0150_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          flt_valid,
  input  logic [2:0]    flt_kind,
  input  logic [31:0]   flt_addr,
  input  logic          path_idle,
  output logic          xlate_en,
  output logic          halted,
  output logic          irq,
  output logic          inv_all,
  output logic          inv_one,
  output logic [19:0]   inv_vpn,
  output logic [31:0]   cfg_q,
  output logic [31:0]   ptbase
);
  localparam logic [AW-1:0] A_CTRL  = AW'('h00);
  localparam logic [AW-1:0] A_CFG   = AW'('h04);
  localparam logic [AW-1:0] A_STAT  = AW'('h08);
  localparam logic [AW-1:0] A_FLALL = AW'('h0C);
  localparam logic [AW-1:0] A_FLONE = AW'('h10);
  localparam logic [AW-1:0] A_PTB   = AW'('h14);
  localparam logic [AW-1:0] A_IST   = AW'('h18);
  localparam logic [AW-1:0] A_ICLR  = AW'('h1C);
  localparam logic [AW-1:0] A_FPAGE = AW'('h24);
  localparam logic [AW-1:0] A_FWR   = AW'('h28);
  localparam logic [AW-1:0] A_FRD   = AW'('h2C);
  localparam logic [AW-1:0] A_FBUS  = AW'('h30);
  localparam logic [AW-1:0] A_VER   = AW'('h34);

  typedef enum logic [1:0] {M_OFF, M_RUN, M_REQ, M_HALT} mode_t;

  mode_t       mode;
  logic [7:0]  ist;
  logic [31:0] fa_page, fa_wr, fa_rd, fa_bus;

  wire wr       = bus_req & bus_we;
  wire flt_take = flt_valid & (mode != M_OFF);
  wire [7:0] set_m = flt_take ? (8'b1 << flt_kind) : 8'b0;
  wire [7:0] clr_m = (wr && bus_addr == A_ICLR) ? bus_wdata[7:0] : 8'b0;

  assign xlate_en = (mode == M_RUN);
  assign halted   = (mode == M_HALT);
  assign irq      = |ist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_OFF;
    end else if (flt_take) begin
      mode <= M_HALT;
    end else if (wr && bus_addr == A_CTRL) begin
      case (bus_wdata)
        32'h5:   mode <= M_RUN;
        32'h7:   if (mode != M_HALT) mode <= M_REQ;
        32'h0:   mode <= M_OFF;
        default: mode <= mode;
      endcase
    end else if (mode == M_REQ && path_idle) begin
      mode <= M_HALT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ist     <= '0;
      fa_page <= '0;
      fa_wr   <= '0;
      fa_rd   <= '0;
      fa_bus  <= '0;
    end else begin
      ist <= (ist & ~clr_m) | set_m;
      if (flt_take) begin
        case (flt_kind)
          3'd0:                fa_page <= flt_addr;
          3'd3:                fa_bus  <= flt_addr;
          3'd1, 3'd4, 3'd5:    fa_rd   <= flt_addr;
          default:             fa_wr   <= flt_addr;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      ptbase  <= '0;
      inv_all <= 1'b0;
      inv_one <= 1'b0;
      inv_vpn <= '0;
    end else begin
      inv_all <= wr && bus_addr == A_FLALL;
      inv_one <= wr && bus_addr == A_FLONE && bus_wdata[0];
      if (wr && bus_addr == A_FLONE && bus_wdata[0]) inv_vpn <= bus_wdata[31:12];
      if (wr && bus_addr == A_CFG) cfg_q  <= bus_wdata & CFG_WMASK;
      if (wr && bus_addr == A_PTB) ptbase <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = (mode == M_OFF) ? 32'h0 : (mode == M_RUN) ? 32'h5 : 32'h7;
      A_CFG:   bus_rdata = cfg_q;
      A_STAT:  bus_rdata = {31'b0, halted};
      A_PTB:   bus_rdata = ptbase;
      A_IST:   bus_rdata = {24'b0, ist};
      A_FPAGE: bus_rdata = fa_page;
      A_FWR:   bus_rdata = fa_wr;
      A_FRD:   bus_rdata = fa_rd;
      A_FBUS:  bus_rdata = fa_bus;
      A_VER:   bus_rdata = {HW_VERSION, 21'b0};
      default: bus_rdata = '0;
    endcase
  end

  // R4: an accepted fault holds the unit at the next edge
  a_r4_fault_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && mode != M_OFF) |=> halted);

  // R3: the held state is entered only through a fault or a drained block request
  a_r3_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> ($past(flt_valid) || $past(path_idle)));

  // R7: the interrupt line rises only after a fault strobe
  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(flt_valid));

  // R8: the enable code without a fault releases the unit
  a_r8_enable_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_CTRL && bus_wdata == 32'h5 && !flt_valid) |=> (xlate_en && !halted));

  // R11: invalidate-all pulses only after a flush-all write
  a_r11_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_all) |-> $past(bus_req && bus_we && bus_addr == A_FLALL));
endmodule

// File: tb/test_iommu_ctl_regs.sv
module test_iommu_ctl_regs;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        bus_req = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        flt_valid = 0;
  logic [2:0]  flt_kind = 0;
  logic [31:0] flt_addr = 0;
  logic        path_idle = 0;
  logic        xlate_en, halted, irq, inv_all, inv_one;
  logic [19:0] inv_vpn;
  logic [31:0] cfg_q, ptbase;

  int errors = 0, checks = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  always #(CLK_P/2) clk = ~clk;

  iommu_ctl_regs i_iommu_ctl_regs (
    .clk, .rst_n, .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .flt_valid, .flt_kind, .flt_addr, .path_idle, .xlate_en, .halted, .irq,
    .inv_all, .inv_one, .inv_vpn, .cfg_q, .ptbase);

  // monitor: compares read data against the scoreboard queue
  initial forever begin
    @(negedge clk);
    #(CLK_P/4);
    if (bus_req && !bus_we) begin
      item_t it;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL unexpected read got=%h", bus_rdata);
      end else begin
        it = sb.pop_front();
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s got=%h exp=%h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                     input logic fv, input logic [2:0] fk, input logic [31:0] fa);
    @(negedge clk);
    bus_req = we; bus_we = we; bus_addr = a; bus_wdata = d;
    flt_valid = fv; flt_kind = fk; flt_addr = fa;
    @(negedge clk);
    bus_req = 0; bus_we = 0; flt_valid = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 3'd0, 32'h0);
  endtask

  task automatic fault(input logic [2:0] k, input logic [31:0] fa);
    cyc(1'b0, 8'h00, 32'h0, 1'b1, k, fa);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
  endtask

  task automatic pchk(input logic [31:0] got, input logic [31:0] e, input string tag);
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  logic [31:0] m_page, m_wr, m_rd, m_bus;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    pchk(xlate_en, 0, "R1 xlate_en");
    pchk(halted, 0, "R1 halted");
    pchk(irq, 0, "R1 irq");
    rd(8'h00, 32'h0, "R1 ctrl");
    rd(8'h08, 32'h0, "R1 status");
    rd(8'h18, 32'h0, "R1 int status");
    rd(8'h04, 32'h0, "R1 cfg");
    rd(8'h14, 32'h0, "R1 ptbase");
    rd(8'h34, 32'h3060_0000, "R10 version");

    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0150_FFFF, "R9 cfg all ones");
    wr(8'h04, 32'h1234_5678);
    #1 pchk(cfg_q, 32'h0010_5678, "R9 cfg_q port");
    rd(8'h04, 32'h0010_5678, "R9 cfg pattern");

    wr(8'h14, 32'hDEAD_B000);
    #1 pchk(ptbase, 32'hDEAD_B000, "R12 ptbase port");
    rd(8'h14, 32'hDEAD_B000, "R12 ptbase read");

    wr(8'h00, 32'h5);
    #1 pchk(xlate_en, 1, "R2 enable");
    rd(8'h00, 32'h5, "R2 ctrl enabled");
    wr(8'h00, 32'h3);
    #1 pchk(xlate_en, 1, "R2 bad code ignored");
    rd(8'h00, 32'h5, "R2 ctrl after bad code");

    wr(8'h0C, 32'h1);
    #1 pchk(inv_all, 1, "R11 inv_all pulse");
    @(negedge clk); #1 pchk(inv_all, 0, "R11 inv_all one cycle");
    wr(8'h10, 32'hABCD_E001);
    #1 pchk(inv_one, 1, "R11 inv_one pulse");
    pchk(inv_vpn, 32'hABCDE, "R11 inv_vpn");
    @(negedge clk); #1 pchk(inv_one, 0, "R11 inv_one one cycle");
    wr(8'h10, 32'h1234_5000);
    #1 pchk(inv_one, 0, "R11 no pulse without bit0");

    path_idle = 0;
    wr(8'h00, 32'h7);
    #1 pchk(xlate_en, 0, "R3 block drops enable");
    pchk(halted, 0, "R3 not held before idle");
    rd(8'h08, 32'h0, "R3 status while draining");
    rd(8'h00, 32'h7, "R3 ctrl block code");
    path_idle = 1;
    @(negedge clk); #1 pchk(halted, 1, "R3 held after idle");
    rd(8'h08, 32'h1, "R3 status held");
    path_idle = 0;
    wr(8'h00, 32'h5);
    #1 pchk(xlate_en, 1, "R8 release from block");
    pchk(halted, 0, "R8 not held");

    fault(3'd0, 32'h1000_0004);
    #1 pchk(halted, 1, "R4 fault holds");
    pchk(irq, 1, "R7 irq on fault");
    rd(8'h18, 32'h01, "R4 status bit 0");
    rd(8'h24, 32'h1000_0004, "R5 page address");
    wr(8'h00, 32'h5);
    #1 pchk(xlate_en, 1, "R8 release after fault");
    pchk(irq, 1, "R7 irq stays until cleared");
    wr(8'h1C, 32'h01);
    #1 pchk(irq, 0, "R7 irq low after clear");
    rd(8'h18, 32'h0, "R6 cleared");

    m_page = 32'h1000_0004; m_wr = 0; m_rd = 0; m_bus = 0;
    for (int k = 0; k < 8; k++) begin
      fault(3'(k), 32'hA000_0000 + k);
      case (k)
        0: m_page = 32'hA000_0000 + k;
        3: m_bus  = 32'hA000_0000 + k;
        1, 4, 5: m_rd = 32'hA000_0000 + k;
        default: m_wr = 32'hA000_0000 + k;
      endcase
      rd(8'h24, m_page, "R5 page reg");
      rd(8'h28, m_wr, "R5 write reg");
      rd(8'h2C, m_rd, "R5 read reg");
      rd(8'h30, m_bus, "R5 bus reg");
    end
    rd(8'h18, 32'hFF, "R4 all kinds set");
    wr(8'h1C, 32'h0F);
    rd(8'h18, 32'hF0, "R6 partial clear");
    #1 pchk(irq, 1, "R7 irq with upper bits");
    wr(8'h1C, 32'hF0);
    #1 pchk(irq, 0, "R7 irq all clear");

    cyc(1'b1, 8'h1C, 32'h04, 1'b1, 3'd2, 32'h5555_0000);
    rd(8'h18, 32'h04, "R6 set wins over clear");
    cyc(1'b1, 8'h00, 32'h5, 1'b1, 3'd1, 32'h6666_0000);
    #1 pchk(halted, 1, "R4 fault beats enable");
    pchk(xlate_en, 0, "R4 no enable on collision");

    wr(8'h1C, 32'hFF);
    wr(8'h00, 32'h0);
    #1 pchk(xlate_en, 0, "R2 disable");
    rd(8'h00, 32'h0, "R2 ctrl off");
    fault(3'd0, 32'h7777_0000);
    #1 pchk(halted, 0, "R4 off ignores fault");
    rd(8'h18, 32'h0, "R4 off no status");
    rd(8'h24, 32'hA000_0000, "R4 off keeps address");

    repeat (2) @(negedge clk);
    if (sb.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard left=%0d exp=0", sb.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule